// File: doc/BRIEF.md
# Layer-Selected Circulant Rotation Network

This block connects the column-group storage of a layered quasi-cyclic LDPC decoder to one row-of-circulants processing unit. On the forward path it takes the active layer number and picks six source columns from the 24 column groups. Each group holds Z soft values. The block rotates each chosen group left by the shift factor of its circulant and hands the six rotated groups to the check-node processor.

On the return path it takes the six updated groups and rotates each one right by the same factor. It then steers each group to the column register it came from and raises that register's write enable. Registers that the processing unit did not touch in this layer are passed through unchanged, and their enables stay low.

Column choices and shift factors are not held in a memory. They come from a closed-form table that is fixed by parameters. Every lane is a small multiplexer indexed by layer, with one input per layer. The block holds no state and is purely combinational.

Top module: `qc_circ_perm`

## Requirements
- R1: For layer p in 0..2 (row slot ROW=0), output group t lane k equals bank register col(p,t) lane (k+sh(p,t)) mod Z. Groups and registers are Z*W-bit slices, with group t at offset t*Z*W and lane k at offset k*W inside it. Here col(p,t) = 4t + ((ROW + p*t) mod 4) and sh(p,t) = (49 + 13p + 19*ROW + 31t) mod Z, with Z=54.
- R2: In layer 0, group 0 is register 0 rotated left by 49: lane 0 holds register lane 49, lane 4 holds lane 53, and lane 5 wraps to lane 0.
- R3: For a valid layer, write-back register col(p,t) lane k equals updated group t lane (k - sh(p,t)) mod Z.
- R4: Feeding the forward output straight back as the update returns every register bit-identical to the bank input, for every layer.
- R5: For a valid layer, exactly six write enables are high, at bit positions col(p,0)..col(p,5).
- R6: A register not addressed in the current layer has its write enable low, and its write-back value equals its bank value.
- R7: Layer code 3 (no layer) drives all forward lanes to zero, raises no write enable, and passes the bank through to the write-back output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| layer_i | input | 2 | Active layer number; 3 selects no layer |
| bank_i | input | NCOL*Z*W (10368) | Current contents of all column registers |
| upd_i | input | NGRP*Z*W (2592) | Updated groups returned by the processing unit |
| fwd_o | output | NGRP*Z*W (2592) | Selected and left-rotated groups to the processing unit |
| wb_o | output | NCOL*Z*W (10368) | Next value for every column register |
| wb_en_o | output | NCOL (24) | Per-register write enable |

## Verification
The bench first checks lanes near the wrap point of a 49-position rotation. A design that rotates the wrong way, or reduces modulo a power of two instead of Z, puts the wrong lane there. For each layer it then runs a forward-then-back round trip. An inverse rotation in the wrong direction, or a group steered to the wrong column, breaks the identity for some register. An independent update pattern is used to expose errors that cancel in the round trip. Unaddressed registers and the unused layer code are checked for pass-through and for silent enables, which catches a design that writes stale data or zeroes.

// File: rtl/qc_circ_perm.sv
`timescale 1ns/1ps
module qc_circ_perm #(
  parameter int Z       = 54,
  parameter int W       = 8,
  parameter int NGRP    = 6,
  parameter int NROW    = 4,
  parameter int NCOL    = NGRP * NROW,
  parameter int NLAY    = 3,
  parameter int ROW     = 0,
  parameter int SH_BASE = 49,
  parameter int SH_P    = 13,
  parameter int SH_S    = 19,
  parameter int SH_T    = 31,
  localparam int LW     = (NLAY > 1) ? $clog2(NLAY) : 1
) (
  input  logic [LW-1:0]        layer_i,
  input  logic [NCOL*Z*W-1:0]  bank_i,
  input  logic [NGRP*Z*W-1:0]  upd_i,
  output logic [NGRP*Z*W-1:0]  fwd_o,
  output logic [NCOL*Z*W-1:0]  wb_o,
  output logic [NCOL-1:0]      wb_en_o
);

  function automatic int col_of(int p, int t);
    return t * NROW + ((ROW + p * t) % NROW);
  endfunction

  function automatic int sh_of(int p, int t);
    return (SH_BASE + SH_P * p + SH_S * ROW + SH_T * t) % Z;
  endfunction

  for (genvar t = 0; t < NGRP; t++) begin : g_grp
    for (genvar k = 0; k < Z; k++) begin : g_lane
      logic [W-1:0] v;
      always_comb begin
        v = '0;
        for (int p = 0; p < NLAY; p++)
          if (layer_i == LW'(p))
            v = bank_i[(col_of(p, t) * Z + (k + sh_of(p, t)) % Z) * W +: W];
      end
      assign fwd_o[(t * Z + k) * W +: W] = v;
    end
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_reg
    logic en;
    always_comb begin
      en = 1'b0;
      for (int p = 0; p < NLAY; p++)
        for (int t = 0; t < NGRP; t++)
          if (layer_i == LW'(p) && col_of(p, t) == c) en = 1'b1;
    end
    assign wb_en_o[c] = en;

    for (genvar k = 0; k < Z; k++) begin : g_lane
      logic [W-1:0] v;
      always_comb begin
        v = bank_i[(c * Z + k) * W +: W];
        for (int p = 0; p < NLAY; p++)
          for (int t = 0; t < NGRP; t++)
            if (layer_i == LW'(p) && col_of(p, t) == c)
              v = upd_i[(t * Z + (k + Z - sh_of(p, t)) % Z) * W +: W];
      end
      assign wb_o[(c * Z + k) * W +: W] = v;
    end
  end

endmodule

// File: rtl/qc_circ_perm_chk.sv
`timescale 1ns/1ps
module qc_circ_perm_chk #(
  parameter int Z    = 54,
  parameter int W    = 8,
  parameter int NGRP = 6,
  parameter int NCOL = 24,
  parameter int NLAY = 3,
  parameter int LW   = 2
) (
  input logic [LW-1:0]       layer_i,
  input logic [NCOL*Z*W-1:0] bank_i,
  input logic [NGRP*Z*W-1:0] upd_i,
  input logic [NGRP*Z*W-1:0] fwd_o,
  input logic [NCOL*Z*W-1:0] wb_o,
  input logic [NCOL-1:0]     wb_en_o
);
  always_comb begin
    if (!$isunknown({layer_i, bank_i, upd_i})) begin
      a_r5_six_enables: assert ($countones(wb_en_o) == ((int'(layer_i) < NLAY) ? NGRP : 0));
      a_r7_idle_zero: assert (int'(layer_i) < NLAY || fwd_o == '0);
      a_r4_round_trip: assert (upd_i != fwd_o || wb_o == bank_i);
      for (int c = 0; c < NCOL; c++)
        a_r6_keep: assert (wb_en_o[c] || wb_o[c*Z*W +: Z*W] == bank_i[c*Z*W +: Z*W]);
    end
  end
endmodule

bind qc_circ_perm qc_circ_perm_chk #(
  .Z(Z), .W(W), .NGRP(NGRP), .NCOL(NCOL), .NLAY(NLAY), .LW(LW)
) u_chk (.*);

// File: tb/tb_qc_circ_perm.sv
`timescale 1ns/1ps
module tb_qc_circ_perm;
  localparam int Z = 54, W = 8, NGRP = 6, NROW = 4, NCOL = 24, NLAY = 3;
  localparam int NV = 6;
  localparam int VL [NV] = '{0, 1, 2, 0, 1, 2};
  localparam int VS [NV] = '{3, 77, 140, 201, 9, 55};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [1:0]           layer;
  logic [NCOL*Z*W-1:0]  bank, wb;
  logic [NGRP*Z*W-1:0]  upd, fwd;
  logic [NCOL-1:0]      en;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  qc_circ_perm dut (.layer_i(layer), .bank_i(bank), .upd_i(upd),
                    .fwd_o(fwd), .wb_o(wb), .wb_en_o(en));

  function automatic int col_m(int p, int t);
    return t * 4 + ((p * t) % 4);
  endfunction
  function automatic int sh_m(int p, int t);
    return (49 + 13 * p + 31 * t) % Z;
  endfunction

  task automatic report(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic fill(int seed);
    for (int c = 0; c < NCOL; c++)
      for (int k = 0; k < Z; k++)
        bank[(c*Z+k)*W +: W] = W'(seed * 37 + c * 11 + k * 3 + c * k);
  endtask

  task automatic check_fwd(string tag, int p);
    int bad = -1, a = 0, e = 0;
    for (int t = 0; t < NGRP; t++)
      for (int k = 0; k < Z; k++) begin
        int ex = (p < NLAY) ? int'(bank[(col_m(p,t)*Z + (k+sh_m(p,t))%Z)*W +: W]) : 0;
        if (bad < 0 && int'(fwd[(t*Z+k)*W +: W]) != ex) begin
          bad = t*Z+k; a = int'(fwd[(t*Z+k)*W +: W]); e = ex;
        end
      end
    report(bad < 0, tag, $sformatf("forward lane %0d layer %0d", bad, p), a, e);
  endtask

  task automatic check_wb(string tag, int p);
    int bad = -1, a = 0, e = 0;
    for (int c = 0; c < NCOL; c++)
      for (int k = 0; k < Z; k++) begin
        int ex = int'(bank[(c*Z+k)*W +: W]);
        for (int t = 0; t < NGRP; t++)
          if (p < NLAY && col_m(p,t) == c)
            ex = int'(upd[(t*Z + (k+Z-sh_m(p,t))%Z)*W +: W]);
        if (bad < 0 && int'(wb[(c*Z+k)*W +: W]) != ex) begin
          bad = c*Z+k; a = int'(wb[(c*Z+k)*W +: W]); e = ex;
        end
      end
    report(bad < 0, tag, $sformatf("write-back lane %0d layer %0d", bad, p), a, e);
  endtask

  task automatic check_en(string tag, int p);
    logic [NCOL-1:0] m = '0;
    if (p < NLAY) for (int t = 0; t < NGRP; t++) m[col_m(p,t)] = 1'b1;
    report(en == m, tag, $sformatf("enable mask layer %0d", p), int'(en), int'(m));
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic settle;
    @(posedge clk); #1;
  endtask

  initial begin
    layer = 2'd3; bank = '0; upd = '0;
    settle();
    check_fwd("R7", 3);
    check_en("R7", 3);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); layer = 2'(VL[i]); fill(VS[i]); upd = '0;
      settle();
      check_fwd("R1", VL[i]);
      @(negedge clk); upd = fwd;
      settle();
      check_wb("R4", VL[i]);
      check_en("R5", VL[i]);
      @(negedge clk);
      for (int t = 0; t < NGRP; t++)
        for (int k = 0; k < Z; k++)
          upd[(t*Z+k)*W +: W] = W'(VS[i] + 5*t + 7*k + t*k + 100);
      settle();
      check_wb("R3", VL[i]);
      check_wb("R6", VL[i]);
    end

    @(negedge clk); layer = 2'd0; fill(12);
    settle();
    report(fwd[0 +: W] == bank[49*W +: W], "R2", "lane 0", int'(fwd[0 +: W]), int'(bank[49*W +: W]));
    report(fwd[4*W +: W] == bank[53*W +: W], "R2", "lane 4", int'(fwd[4*W +: W]), int'(bank[53*W +: W]));
    report(fwd[5*W +: W] == bank[0 +: W], "R2", "lane 5 wrap", int'(fwd[5*W +: W]), int'(bank[0 +: W]));

    @(negedge clk); layer = 2'd3; fill(99);
    for (int j = 0; j < NGRP*Z; j++) upd[j*W +: W] = W'(j + 1);
    settle();
    check_fwd("R7", 3);
    check_en("R7", 3);
    check_wb("R7", 3);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule